// File: doc/BRIEF.md
# Translation Cache with Invalidation

This block holds recently used virtual-to-physical page translations for a two-level page-table unit with 4 KiB pages. A requester presents a 32-bit virtual address. In the same cycle the cache answers with a hit and the physical address, a permission fault, or a miss. On a miss it raises a request to the table walker, which later returns the page-table entry through the fill port.

The cache is fully associative and holds eight entries. New pages are placed round-robin. Each stored entry keeps the physical page number, the read and write permission bits and six cache-attribute bits. The attribute bits are only passed through to the requester. The register block can remove one page by writing a virtual address, or remove every page at once. Software flushes everything before it acknowledges a page fault, so no stale translation outlives the handling of that fault.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid. With no request, the hit, miss, fault and walker-request outputs are 0, and the physical address and attribute outputs are 0.
- R2: A request that matches a valid entry with sufficient permission raises rspHit in the same cycle. rspPaddr is then the stored page number in bits 31:12 joined with request bits 11:0, and rspAttr carries the stored attribute bits.
- R3: A request whose page (address bits 31:12) is not cached raises rspMiss and missValid in the same cycle, with missVpn equal to request bits 31:12. Hit and fault stay 0.
- R4: The fill entry uses this format: bit 0 valid, bit 1 readable, bit 2 writable, bits 8:3 cache attributes, bits 31:12 physical page. A fill takes effect for lookups from the next cycle. A fill whose bit 0 is 0 is ignored.
- R5: A write request that matches an entry without the writable bit, or a read request that matches an entry without the readable bit, raises rspFault instead of rspHit or rspMiss, and rspPaddr stays 0.
- R6: The eight entries are allocated round-robin starting at entry 0. The ninth distinct page filled after reset evicts the first one.
- R7: Filling a page that is already cached overwrites that entry in place. The replacement position does not advance and no duplicate entry is made.
- R8: invOneValid removes the entry whose page equals bits 31:12 of invOneVaddr. Bits 11:0 of invOneVaddr are ignored, and other entries are kept.
- R9: invAllValid removes every entry in one cycle.
- R10: If a fill arrives in the same cycle as invAllValid, or as invOneValid for the same page, the invalidate wins. The page ends up uncached and the replacement position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqVaddr | input | 32 | Virtual address of the lookup |
| reqWrite | input | 1 | 1 for a write access, 0 for a read access |
| rspHit | output | 1 | Translation found, permission granted |
| rspMiss | output | 1 | Page not cached |
| rspFault | output | 1 | Page cached, permission denied |
| rspPaddr | output | 32 | Translated physical address (0 unless hit) |
| rspAttr | output | 6 | Cache attributes of the hit entry (0 unless hit) |
| missValid | output | 1 | Walk request to the table walker |
| missVpn | output | 20 | Virtual page to walk |
| fillValid | input | 1 | Fill entry present |
| fillVpn | input | 20 | Virtual page being filled |
| fillPte | input | 32 | Page-table entry for the fill |
| invOneValid | input | 1 | Invalidate a single page |
| invOneVaddr | input | 32 | Address whose page is invalidated |
| invAllValid | input | 1 | Invalidate all entries |

## Verification
A fill and an invalidate can arrive in the same cycle, and they decide the fate of the same entry. The bench drives a fill together with a single-page invalidate for that page, and separately a fill together with a global flush. It then checks that the page misses afterwards. It also checks that the replacement position did not advance: after the colliding cycle it fills one more page into a nearly full cache and confirms that the oldest page still hits. A separate test refills a cached page and confirms, in the same way, that the replacement position stayed put.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  parameter int ENTRIES = 8;
  parameter int VA_W    = 32;
  parameter int OFF_W   = 12;
  parameter int ATTR_W  = 6;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PA_W   = 32;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  // page-table entry field positions
  localparam int PTE_VALID = 0;
  localparam int PTE_RD    = 1;
  localparam int PTE_WR    = 2;
  localparam int PTE_ATTR  = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic              rd;
    logic              wr;
    logic [ATTR_W-1:0] attr;
  } entry_t;

  typedef struct packed {
    logic [ENTRIES-1:0] wrEn;
    logic [ENTRIES-1:0] clr;
  } strobe_t;
endpackage

// File: rtl/xlc_data.sv
module xlc_data
  import xlc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  entry_t             fillEntry,
  input  logic [VPN_W-1:0]   lookVpn,
  input  logic [VPN_W-1:0]   invVpn,
  output logic [ENTRIES-1:0] lookMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] invMatch,
  output entry_t             selEntry
);
  logic [ENTRIES-1:0] validVec;
  entry_t             entryQ [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
        entryQ[g]   <= '0;
      end else if (strobes.wrEn[g]) begin
        validVec[g] <= 1'b1;
        entryQ[g]   <= fillEntry;
      end else if (strobes.clr[g]) begin
        validVec[g] <= 1'b0;
      end
    end
    assign lookMatch[g] = validVec[g] && (entryQ[g].vpn == lookVpn);
    assign fillMatch[g] = validVec[g] && (entryQ[g].vpn == fillEntry.vpn);
    assign invMatch[g]  = validVec[g] && (entryQ[g].vpn == invVpn);
  end

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lookMatch[i]) selEntry = selEntry | entryQ[i];
  end

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch)); // R7
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clr == '1) |=> (validVec == '0)); // R9
  AST_INV_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.clr) |=> ((validVec & $past(invMatch) & ~$past(strobes.wrEn)) == '0)); // R8
endmodule

// File: rtl/xlc_ctrl.sv
module xlc_ctrl
  import xlc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               fillValid,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic               fillPteValid,
  input  logic               invOneValid,
  input  logic [VPN_W-1:0]   invVpn,
  input  logic               invAllValid,
  input  logic [ENTRIES-1:0] lookMatch,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic [ENTRIES-1:0] invMatch,
  input  entry_t             selEntry,
  output strobe_t            strobes,
  output logic               rspHit,
  output logic               rspMiss,
  output logic               rspFault,
  output logic [PA_W-1:0]    rspPaddr,
  output logic [ATTR_W-1:0]  rspAttr,
  output logic               missValid,
  output logic [VPN_W-1:0]   missVpn
);
  logic [IDX_W-1:0] rrPtr;
  logic killFill, doFill, reuse, allocNew, found, permOk;

  assign killFill = invAllValid || (invOneValid && (invVpn == fillVpn));
  assign doFill   = fillValid && fillPteValid && !killFill;
  assign reuse    = |fillMatch;
  assign allocNew = doFill && !reuse;

  always_comb begin
    strobes.wrEn = '0;
    if (doFill) begin
      if (reuse) strobes.wrEn = fillMatch;
      else       strobes.wrEn[rrPtr] = 1'b1;
    end
    if (invAllValid)      strobes.clr = '1;
    else if (invOneValid) strobes.clr = invMatch;
    else                  strobes.clr = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rrPtr <= '0;
    else if (allocNew) rrPtr <= (rrPtr == IDX_W'(ENTRIES-1)) ? '0 : rrPtr + 1'b1;
  end

  assign found    = reqValid && (|lookMatch);
  assign permOk   = reqWrite ? selEntry.wr : selEntry.rd;
  assign rspHit   = found && permOk;
  assign rspFault = found && !permOk;
  assign rspMiss  = reqValid && !(|lookMatch);
  assign missValid = rspMiss;
  assign missVpn  = rspMiss ? reqVaddr[VA_W-1:OFF_W] : '0;
  assign rspPaddr = rspHit ? {selEntry.ppn, reqVaddr[OFF_W-1:0]} : '0;
  assign rspAttr  = rspHit ? selEntry.attr : '0;

  AST_WRITE_PERM: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && reqWrite) |-> selEntry.wr); // R5
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspHit, rspMiss, rspFault}) == 32'(reqValid)); // R3
  AST_KILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && invAllValid) |-> (strobes.wrEn == '0)); // R10
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqVaddr,
  input  logic        reqWrite,
  output logic        rspHit,
  output logic        rspMiss,
  output logic        rspFault,
  output logic [31:0] rspPaddr,
  output logic [5:0]  rspAttr,
  output logic        missValid,
  output logic [19:0] missVpn,
  input  logic        fillValid,
  input  logic [19:0] fillVpn,
  input  logic [31:0] fillPte,
  input  logic        invOneValid,
  input  logic [31:0] invOneVaddr,
  input  logic        invAllValid
);
  strobe_t            strobes;
  entry_t             fillEntry, selEntry;
  logic [ENTRIES-1:0] lookMatch, fillMatch, invMatch;

  assign fillEntry.vpn  = fillVpn;
  assign fillEntry.ppn  = fillPte[PA_W-1:OFF_W];
  assign fillEntry.rd   = fillPte[PTE_RD];
  assign fillEntry.wr   = fillPte[PTE_WR];
  assign fillEntry.attr = fillPte[PTE_ATTR +: ATTR_W];

  xlc_data uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fillEntry(fillEntry),
    .lookVpn(reqVaddr[VA_W-1:OFF_W]), .invVpn(invOneVaddr[VA_W-1:OFF_W]),
    .lookMatch(lookMatch), .fillMatch(fillMatch), .invMatch(invMatch),
    .selEntry(selEntry)
  );

  xlc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVaddr(reqVaddr), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPteValid(fillPte[PTE_VALID]), .invOneValid(invOneValid),
    .invVpn(invOneVaddr[VA_W-1:OFF_W]), .invAllValid(invAllValid),
    .lookMatch(lookMatch), .fillMatch(fillMatch), .invMatch(invMatch),
    .selEntry(selEntry), .strobes(strobes), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspFault(rspFault), .rspPaddr(rspPaddr),
    .rspAttr(rspAttr), .missValid(missValid), .missVpn(missVpn)
  );
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, fillValid = 0, invOneValid = 0, invAllValid = 0;
  logic [31:0] reqVaddr = '0, fillPte = '0, invOneVaddr = '0;
  logic [19:0] fillVpn = '0;
  logic rspHit, rspMiss, rspFault, missValid;
  logic [31:0] rspPaddr;
  logic [5:0]  rspAttr;
  logic [19:0] missVpn;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  xlat_cache u0 (.*);

  localparam logic [1:0] LOOK = 2'd0, FILL = 2'd1, INV1 = 2'd2, INVA = 2'd3;
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] pte;
    logic        wr;
    logic [2:0]  exp;   // {hit, miss, fault}
    logic [31:0] pa;
  } vec_t;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{LOOK, 32'h12345678, 32'h0,        1'b0, 3'b010, 32'h0},
    '{FILL, 32'h12345000, 32'hABCDE007, 1'b0, 3'b000, 32'h0},
    '{LOOK, 32'h12345678, 32'h0,        1'b0, 3'b100, 32'hABCDE678},
    '{LOOK, 32'h12345FFF, 32'h0,        1'b1, 3'b100, 32'hABCDEFFF},
    '{FILL, 32'h00001000, 32'h55555003, 1'b0, 3'b000, 32'h0},
    '{LOOK, 32'h00001004, 32'h0,        1'b1, 3'b001, 32'h0},
    '{LOOK, 32'h00001004, 32'h0,        1'b0, 3'b100, 32'h55555004},
    '{FILL, 32'h00002000, 32'h66666005, 1'b0, 3'b000, 32'h0},
    '{LOOK, 32'h00002010, 32'h0,        1'b0, 3'b001, 32'h0},
    '{FILL, 32'h00003000, 32'h77777006, 1'b0, 3'b000, 32'h0},
    '{LOOK, 32'h00003000, 32'h0,        1'b0, 3'b010, 32'h0},
    '{INV1, 32'h12345ABC, 32'h0,        1'b0, 3'b000, 32'h0},
    '{LOOK, 32'h12345678, 32'h0,        1'b0, 3'b010, 32'h0},
    '{LOOK, 32'h00001008, 32'h0,        1'b0, 3'b100, 32'h55555008},
    '{INVA, 32'h0,        32'h0,        1'b0, 3'b000, 32'h0},
    '{LOOK, 32'h00001008, 32'h0,        1'b0, 3'b010, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle of fill and/or invalidates, starting and ending at a negedge
  task automatic cyc(input logic fv, input logic [31:0] fa, input logic [31:0] pte,
                     input logic iv, input logic [31:0] ia, input logic av);
    fillValid = fv; fillVpn = fa[31:12]; fillPte = pte;
    invOneValid = iv; invOneVaddr = ia; invAllValid = av;
    @(negedge clk);
    fillValid = 0; invOneValid = 0; invAllValid = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic w, input logic [2:0] exp,
                      input logic [31:0] pa, input string tag);
    reqValid = 1; reqVaddr = a; reqWrite = w;
    #2;
    chk({rspHit, rspMiss, rspFault} == exp, tag, 64'({rspHit, rspMiss, rspFault}), 64'(exp));
    chk(rspPaddr == pa, tag, 64'(rspPaddr), 64'(pa));
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R1: watchdog expired, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state with no request
    #2;
    chk({rspHit, rspMiss, rspFault, missValid} == 4'b0, "R1 idle flags", 64'({rspHit, rspMiss, rspFault, missValid}), 64'h0);
    chk(rspPaddr == 0 && rspAttr == 0, "R1 idle data", 64'({rspPaddr, rspAttr}), 64'h0);
    @(negedge clk);

    // table walk: R2 hit, R3 miss, R4 fill format, R5 permission, R8 single, R9 all
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        FILL: cyc(1, VECS[i].addr, VECS[i].pte, 0, 0, 0);
        INV1: cyc(0, 0, 0, 1, VECS[i].addr, 0);
        INVA: cyc(0, 0, 0, 0, 0, 1);
        default: begin
          if (VECS[i].exp[0])      look(VECS[i].addr, VECS[i].wr, VECS[i].exp, VECS[i].pa, "R5 table fault");
          else if (VECS[i].exp[1]) look(VECS[i].addr, VECS[i].wr, VECS[i].exp, VECS[i].pa, "R3 R8 R9 table miss");
          else                     look(VECS[i].addr, VECS[i].wr, VECS[i].exp, VECS[i].pa, "R2 R4 table hit");
        end
      endcase
    end

    // R3: walker request carries the page number
    reqValid = 1; reqVaddr = 32'hFEDCB123; reqWrite = 0;
    #2;
    chk(missValid && missVpn == 20'hFEDCB, "R3 missVpn", 64'({missValid, missVpn}), 64'({1'b1, 20'hFEDCB}));
    @(negedge clk); reqValid = 0;

    // R4: attribute bits 8:3 carried out on a hit
    cyc(1, 32'h0ABCD000, 32'h999991FF, 0, 0, 0);
    reqValid = 1; reqVaddr = 32'h0ABCD010; reqWrite = 1;
    #2;
    chk(rspHit && rspAttr == 6'h3F, "R4 attr", 64'({rspHit, rspAttr}), 64'({1'b1, 6'h3F}));
    @(negedge clk); reqValid = 0;

    // R7 then R6: refill in place, then round-robin eviction
    doReset();
    cyc(1, 32'h0A000000, 32'h11111003, 0, 0, 0);
    cyc(1, 32'h0A000000, 32'h22222003, 0, 0, 0);
    for (int k = 1; k < 8; k++) cyc(1, 32'h0A000000 + (k << 12), 32'h33333003, 0, 0, 0);
    look(32'h0A000044, 0, 3'b100, 32'h22222044, "R7 refill kept");
    look(32'h0A007000, 0, 3'b100, 32'h33333000, "R7 last page");
    cyc(1, 32'h0B000000, 32'h44444003, 0, 0, 0);
    look(32'h0A000044, 0, 3'b010, 32'h0, "R6 oldest evicted");
    look(32'h0A001000, 0, 3'b100, 32'h33333000, "R6 second kept");
    look(32'h0B000008, 0, 3'b100, 32'h44444008, "R6 new page");

    // R10: fill and single invalidate of the same page collide
    doReset();
    for (int k = 0; k < 7; k++) cyc(1, 32'h00100000 + (k << 12), 32'h50000003, 0, 0, 0);
    cyc(1, 32'h00200000, 32'h60000003, 1, 32'h00200FFF, 0);
    look(32'h00200000, 0, 3'b010, 32'h0, "R10 inv-one wins");
    cyc(1, 32'h00300000, 32'h70000003, 0, 0, 0);
    look(32'h00100004, 0, 3'b100, 32'h50000004, "R10 pointer held");
    look(32'h00300004, 0, 3'b100, 32'h70000004, "R10 next fill");

    // R10 with a global flush; R9 everything gone
    cyc(1, 32'h00400000, 32'h80000003, 0, 0, 1);
    look(32'h00400000, 0, 3'b010, 32'h0, "R10 inv-all wins");
    look(32'h00300004, 0, 3'b010, 32'h0, "R9 flushed");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule